// File: doc/BRIEF.md
# Peripheral Request-to-Channel Router

This block sits between a set of peripheral request lines and a bank of physical transfer channels. A small mapping register belongs to each request line. The register holds an enable flag and a channel index. While a request line is high and its mapping is enabled, the selected channel sees a request on the following clock. Several request lines may point at one channel, and their requests then merge.

Software programs the mappings through a plain register port with a write strobe and a combinational read. The byte address of a request's mapping depends on its request number. Numbers below 64 sit in a low window that starts at 0x100. Numbers from 64 upward sit in a high window that starts at 0x1100. Consecutive entries are one 32-bit word apart in both windows. The usual sequence is to write the enable flag together with the channel index just before the channel is started.

Top module: `dreq_router`

## Requirements
- R1: A synchronous active-low reset disables every mapping. Afterwards every mapping register reads zero and no channel request is driven.
- R2: A request number n below 64 has its mapping register at byte address 0x100 + 4*n.
- R3: A request number n of 64 or above has its mapping register at byte address 0x1100 + 4*(n - 64).
- R4: Within a mapping word, bit 7 is the enable flag and bits 4:0 hold the channel index. All other bits are discarded on write and read as zero.
- R5: When a request line is high and its mapping is enabled, the channel named by its index is asserted on `ch_req` one clock later.
- R6: A mapping whose enable flag is clear drives no channel, whatever its request line does.
- R7: When several enabled mappings name the same channel, that channel is the OR of their request lines.
- R8: A read from any address that is not a word-aligned mapping register returns zero. A write to such an address changes no mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 16 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| req_in | input | 128 | Peripheral request lines, one per request number |
| ch_req | output | 32 | Registered request to each physical channel |

## Verification
The hardest case to reach from the ports is a channel driven by several mappings at once, some enabled and some not, while the request pattern switches on every cycle. Uniformly random channel indices would almost never collide in that way. The random phase therefore draws channel indices from a narrow range and leaves about a third of the mappings disabled, so that merging and masking happen together often. Directed writes to misaligned addresses, the gap between the windows and the edges of each window are then followed by a read-back of the whole bank. That read-back shows that no stray write changed any mapping.

// File: rtl/dreq_router_pkg.sv
// Shared definitions for the request router: field layout of a mapping
// word and the address windows of the mapping bank.
package dreq_router_pkg;

    localparam int CHAN_W      = 5;
    localparam int EN_BIT      = 7;
    localparam int LO_BASE     = 32'h0100;
    localparam int HI_BASE     = 32'h1100;
    localparam int WIN_ENTRIES = 64;

    typedef struct packed {
        logic              en;
        logic [CHAN_W-1:0] chan;
    } map_entry_t;

endpackage

// File: rtl/dreq_addr_decode.sv
// Address decoder for the mapping bank.
// It turns a byte address into a request index and a hit flag.
// Assumes word-aligned entries: the low window covers requests 0..63 and
// the high window covers requests 64 and up.
module dreq_addr_decode #(
    parameter int NUM_REQ = 128,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [IDX_W-1:0]  idx_o
);
    import dreq_router_pkg::*;

    localparam int LO_CNT = (NUM_REQ < WIN_ENTRIES) ? NUM_REQ : WIN_ENTRIES;
    localparam int HI_CNT = (NUM_REQ > WIN_ENTRIES) ? NUM_REQ - WIN_ENTRIES : 0;

    logic [31:0] a32;
    logic [31:0] lo_off, hi_off;
    logic        lo_hit, hi_hit;

    // Range-check both windows and form the entry index.
    always_comb begin
        a32    = 32'(addr_i);
        lo_off = a32 - LO_BASE;
        hi_off = a32 - HI_BASE;
        lo_hit = (a32[1:0] == 2'b00) && (a32 >= LO_BASE) && (lo_off < 32'(4 * LO_CNT));
        hi_hit = (HI_CNT > 0) && (a32[1:0] == 2'b00) && (a32 >= HI_BASE)
                 && (hi_off < 32'(4 * HI_CNT));
        hit_o  = lo_hit || hi_hit;
        if (hi_hit) idx_o = IDX_W'(32'(WIN_ENTRIES) + (hi_off >> 2));
        else        idx_o = IDX_W'(lo_off >> 2);
    end

    // R8
    always_comb begin
        if (hit_o) begin
            decode_in_range_chk: assert (32'(idx_o) < 32'(NUM_REQ) && addr_i[1:0] == 2'b00);
        end
    end

endmodule

// File: rtl/dreq_map_bank.sv
// Mapping register bank: one entry per request line, written through the
// register port and read back combinationally.
// Assumes the decoder delivers an in-range index whenever hit_i is high.
module dreq_map_bank
    import dreq_router_pkg::*;
#(
    parameter int NUM_REQ = 128,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic                          hit_i,
    input  logic [IDX_W-1:0]              idx_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [DATA_W-1:0]             rdata_o,
    output map_entry_t [NUM_REQ-1:0]      map_o
);
    map_entry_t [NUM_REQ-1:0] map_q;

    logic unused_wbits;
    assign unused_wbits = ^{wdata_i[DATA_W-1:EN_BIT+1], wdata_i[EN_BIT-1:CHAN_W]};

    // Clear on reset and capture only the enable and channel fields on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (wr_i && hit_i) begin
            map_q[idx_i].en   <= wdata_i[EN_BIT];
            map_q[idx_i].chan <= wdata_i[CHAN_W-1:0];
        end
    end

    // Return the selected entry in its word layout, or zero on a miss.
    always_comb begin
        rdata_o = '0;
        if (hit_i) begin
            rdata_o[EN_BIT]       = map_q[idx_i].en;
            rdata_o[CHAN_W-1:0]   = map_q[idx_i].chan;
        end
    end

    assign map_o = map_q;

    // R1
    reset_clears_bank_chk: assert property (@(posedge clk) !rst_n |=> (map_q == '0));

    // R8
    stray_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !hit_i) |=> $stable(map_q));

endmodule

// File: rtl/dreq_req_combine.sv
// Request combiner: ORs every enabled, asserted request line onto the
// channel that its entry names, and registers the channel vector.
// Assumes channel indices at or above NUM_CH simply drive nothing.
module dreq_req_combine
    import dreq_router_pkg::*;
#(
    parameter int NUM_REQ = 128,
    parameter int NUM_CH  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  map_entry_t [NUM_REQ-1:0] map_i,
    input  logic [NUM_REQ-1:0]       req_i,
    output logic [NUM_CH-1:0]        ch_req_o
);
    logic [NUM_CH-1:0] ch_nxt;

    // Build each channel as the OR over all mappings that select it.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            ch_nxt[c] = 1'b0;
            for (int r = 0; r < NUM_REQ; r++) begin
                if (map_i[r].en && req_i[r] && (32'(map_i[r].chan) == 32'(c)))
                    ch_nxt[c] = 1'b1;
            end
        end
    end

    // Register the combined channel requests.
    always_ff @(posedge clk) begin
        if (!rst_n) ch_req_o <= '0;
        else        ch_req_o <= ch_nxt;
    end

    // R6
    idle_lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i == '0) |=> (ch_req_o == '0)));

    generate
        if (NUM_CH >= (1 << CHAN_W)) begin : g_fwd_chk
            for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
                // R5
                mapped_req_reaches_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (map_i[r].en && req_i[r]) |=> ch_req_o[$past(map_i[r].chan)]);
            end
        end
    endgenerate

endmodule

// File: rtl/dreq_router.sv
// Top of the peripheral request router: address decoder, mapping bank and
// request combiner. Register reads are combinational; channel requests
// are registered once.
module dreq_router
    import dreq_router_pkg::*;
#(
    parameter int NUM_REQ = 128,
    parameter int NUM_CH  = 32,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_REQ-1:0] req_in,
    output logic [NUM_CH-1:0] ch_req
);
    logic                     hit;
    logic [IDX_W-1:0]         idx;
    map_entry_t [NUM_REQ-1:0] map;

    dreq_addr_decode #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_decode (
        .addr_i (reg_addr),
        .hit_o  (hit),
        .idx_o  (idx)
    );

    dreq_map_bank #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .hit_i   (hit),
        .idx_i   (idx),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .map_o   (map)
    );

    dreq_req_combine #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_combine (
        .clk      (clk),
        .rst_n    (rst_n),
        .map_i    (map),
        .req_i    (req_in),
        .ch_req_o (ch_req)
    );

    // R1
    reset_quiets_channels_chk: assert property (@(posedge clk) !rst_n |=> (ch_req == '0));

    // R4
    reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[DATA_W-1:EN_BIT+1] == '0) && (reg_rdata[EN_BIT-1:CHAN_W] == '0));

endmodule

// File: tb/dreq_router_tb.sv
`timescale 1ns/1ps
module dreq_router_tb;

    localparam int NREQ = 128;
    localparam int NCH  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NREQ-1:0] req_in = '0;
    logic [NCH-1:0]  ch_req;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;
    logic [7:0] mdl [NREQ];

    always #5 clk = ~clk;

    dreq_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in), .ch_req(ch_req)
    );

    function automatic int addr_idx(input logic [15:0] a);
        int v = int'(a);
        if (v[1:0] != 2'b00) return -1;
        if (v >= 'h100 && v < 'h100 + 4*64) return (v - 'h100) / 4;
        if (v >= 'h1100 && v < 'h1100 + 4*(NREQ-64)) return 64 + (v - 'h1100) / 4;
        return -1;
    endfunction

    function automatic logic [15:0] idx_addr(input int n);
        if (n < 64) return 16'('h100 + 4*n);
        return 16'('h1100 + 4*(n-64));
    endfunction

    function automatic logic [31:0] exp_read(input logic [15:0] a);
        int i = addr_idx(a);
        if (i < 0) return 32'h0;
        return {24'h0, mdl[i]};
    endfunction

    function automatic logic [NCH-1:0] exp_ch(input logic [NREQ-1:0] r);
        logic [NCH-1:0] e = '0;
        for (int i = 0; i < NREQ; i++)
            if (mdl[i][7] && r[i]) e[mdl[i][4:0]] = 1'b1;
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        int i = addr_idx(a);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (i >= 0) mdl[i] = {d[7], 2'b00, d[4:0]};
    endtask

    task automatic read_chk(input string tag, input logic [15:0] a);
        @(negedge clk);
        reg_addr = a;
        #1 chk(tag, reg_rdata, exp_read(a));
    endtask

    task automatic req_chk(input string tag, input logic [NREQ-1:0] r);
        @(negedge clk);
        req_in = r;
        @(negedge clk);
        chk(tag, 32'(ch_req), 32'(exp_ch(r)));
    endtask

    task automatic bank_chk(input string tag);
        for (int n = 0; n < NREQ; n++) read_chk(tag, idx_addr(n));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [NREQ-1:0] rv;
        seed = int'($urandom(32'h1f2e3d4c));
        for (int i = 0; i < NREQ; i++) mdl[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        read_chk("R1 low entry after reset", 16'h0100);
        read_chk("R1 high entry after reset", 16'h11FC);
        req_chk("R1 no channel after reset", '1);

        // R2, R4: low window edges, reserved bits dropped
        do_write(16'h0100, 32'hFFFF_FFFF);
        read_chk("R4 reserved bits read zero", 16'h0100);
        do_write(16'h01FC, 32'h0000_0083);
        read_chk("R2 last low entry", 16'h01FC);
        // R3: high window edges
        do_write(16'h1100, 32'h0000_0085);
        read_chk("R3 first high entry", 16'h1100);
        do_write(16'h11FC, 32'h0000_0083);
        read_chk("R3 last high entry", 16'h11FC);

        // R5: single mapped request
        req_chk("R5 req0 to ch31", 128'h1);
        req_chk("R5 req64 to ch5", 128'h1 << 64);
        req_chk("R5 release", '0);
        // R6: disabled entry
        do_write(idx_addr(5), 32'h0000_0002);
        req_chk("R6 disabled entry quiet", 128'h1 << 5);
        // R7: two entries onto channel 3
        req_chk("R7 req63 alone", 128'h1 << 63);
        req_chk("R7 req127 alone", 128'h1 << 127);
        req_chk("R7 both merged", (128'h1 << 63) | (128'h1 << 127));

        // R8: stray writes ignored, misses read zero
        do_write(16'h0102, 32'h0000_0081);
        do_write(16'h0200, 32'h0000_0081);
        do_write(16'h10FC, 32'h0000_0081);
        do_write(16'h1200, 32'h0000_0081);
        do_write(16'h00FC, 32'h0000_0081);
        read_chk("R8 misaligned reads zero", 16'h0102);
        read_chk("R8 gap reads zero", 16'h0200);
        read_chk("R8 below high window reads zero", 16'h10FC);
        read_chk("R8 past high window reads zero", 16'h1200);
        bank_chk("R8 bank intact after stray writes");

        // Random phase: narrow channel range to force merging (R7), some disabled (R6)
        for (int it = 0; it < 600; it++) begin
            int sel = int'($urandom_range(0, 9));
            if (sel < 4) begin
                int n = int'($urandom_range(0, NREQ-1));
                logic [31:0] d = $urandom();
                d[7] = ($urandom_range(0, 2) != 0);
                d[4:0] = 5'($urandom_range(0, 5));
                do_write(idx_addr(n), d);
            end else if (sel < 6) begin
                read_chk("R2 R3 R8 random read", 16'($urandom_range(0, 'h1FFF)));
            end else if (sel < 7) begin
                do_write(16'($urandom_range(0, 'h1FFF)), $urandom());
            end else begin
                rv = {$urandom(), $urandom(), $urandom(), $urandom()};
                req_chk("R5 R6 R7 random requests", rv);
            end
        end
        bank_chk("R4 R8 bank after random phase");

        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < NREQ; i++) mdl[i] = 8'h00;
        req_chk("R1 channels quiet after reset", '1);
        bank_chk("R1 bank clear after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule